// File: doc/BRIEF.md
# Rotating Parity Single-Block Write Engine

This block manages a block-interleaved array of N data lanes plus one parity position, held as N+1 internal single-port lane memories. Blocks at the same address in every lane form a stripe. One block of each stripe holds the XOR of the stripe's N data blocks. The lane that holds this parity block changes from stripe to stripe, so parity traffic is spread over all lanes.

A client issues one write at a time. The write carries a logical block number, one data word and a mode bit. The engine maps the block number to a stripe, a data lane and that stripe's parity lane, and then keeps the stripe consistent in one of two ways:
- **Delta mode** fetches the old data block and the old parity block, folds the new data into the parity, and stores both words.
- **Recompute mode** fetches the stripe's other N-1 data blocks and rebuilds the parity from them and the new data.

Per-request read and write counters report the lane traffic each update cost. A combinational inspection port exposes any lane word.

Top module: `rot_parity_updater`

## Requirements
- R1: For logical block b, stripe s = b / N and position i = b mod N. The parity lane is N - (s mod (N+1)). Data lanes are assigned to positions in ascending order, skipping the parity lane. Every block of stripe s sits at address s of its lane.
- R2: After reset every lane word is zero, `req_ready` is 1, `done` is 0 and both counters are 0.
- R3: After every update, the XOR of all N+1 words of the touched stripe is zero.
- R4: With `req_recompute` = 0 (delta mode), an update makes exactly 2 lane reads and 2 lane writes, as reported by `rd_count` and `wr_count` at `done`.
- R5: With `req_recompute` = 1 (recompute mode), an update makes exactly N-1 lane reads and 2 lane writes.
- R6: A request is taken only in a cycle where `req_ready` is 1, which happens only when the engine is idle. A `req_valid` raised while the engine is busy is ignored and leaves the lanes untouched.
- R7: `done` is a one-cycle pulse in the cycle after the parity write. The counters then hold their values until the next request is accepted.
- R8: An update changes only the addressed data word and the parity word of its stripe. Every other lane word keeps its value.
- R9: Both modes leave the array in the same state. The stripe parity always equals the XOR of the stripe's current data words, whichever mode wrote it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Engine idle; request taken this cycle if valid |
| req_lbn | input | LBW | Logical block number |
| req_data | input | DW | New block contents |
| req_recompute | input | 1 | 0 = delta update, 1 = full-stripe recompute |
| done | output | 1 | One-cycle completion pulse |
| rd_count | output | CW | Lane reads made by the last request |
| wr_count | output | CW | Lane writes made by the last request |
| peek_lane | input | LW | Inspection lane select |
| peek_addr | input | AW | Inspection stripe address |
| peek_data | output | DW | Word stored at the inspected lane and address |

## Verification
Two events can coincide in one cycle: the completion pulse of one update and a request that the client has held valid for the next. The bench provokes this by holding a second request on the inputs from the moment the first one is taken until after its completion.

It then judges three things:
- The held request is not taken during the busy or completion cycles.
- It is taken once the engine is back to idle.
- It produces exactly one further completion, with the lane contents matching a reference model that applied the two writes in order.

A separate burst of requests, raised and dropped while the engine is busy, must leave the array equal to the model.

// File: rtl/rot_parity_updater.sv
module rot_parity_updater #(
  parameter int N     = 4,
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int LANES = N + 1,
  localparam int LW    = $clog2(LANES),
  localparam int AW    = $clog2(DEPTH),
  localparam int LBW   = $clog2(N * DEPTH),
  localparam int CW    = $clog2(N + 1) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [LBW-1:0] req_lbn,
  input  logic [DW-1:0]  req_data,
  input  logic           req_recompute,
  output logic           done,
  output logic [CW-1:0]  rd_count,
  output logic [CW-1:0]  wr_count,
  input  logic [LW-1:0]  peek_lane,
  input  logic [AW-1:0]  peek_addr,
  output logic [DW-1:0]  peek_data
);

  typedef enum logic [3:0] {
    S_IDLE, S_MAP, S_RD_OLD, S_RD_PAR, S_COMPUTE,
    S_SCAN, S_WR_DATA, S_WR_PAR, S_DONE
  } state_t;

  state_t          state;
  logic [DW-1:0]   mem [LANES][DEPTH];
  logic [LBW-1:0]  lbn_q;
  logic [DW-1:0]   data_q;
  logic            mode_q;
  logic [AW-1:0]   stripe_q;
  logic [LW-1:0]   dlane_q, plane_q, scan_q;
  logic [DW-1:0]   acc;

  int s_i, pos_i, par_i, dat_i;
  always_comb begin
    s_i   = int'(lbn_q) / N;
    pos_i = int'(lbn_q) % N;
    par_i = N - (s_i % LANES);
    dat_i = (pos_i < par_i) ? pos_i : pos_i + 1;
  end

  assign req_ready = (state == S_IDLE);
  assign done      = (state == S_DONE);
  assign peek_data = mem[peek_lane][peek_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      lbn_q    <= '0;
      data_q   <= '0;
      mode_q   <= 1'b0;
      stripe_q <= '0;
      dlane_q  <= '0;
      plane_q  <= '0;
      scan_q   <= '0;
      acc      <= '0;
      rd_count <= '0;
      wr_count <= '0;
      for (int l = 0; l < LANES; l++)
        for (int a = 0; a < DEPTH; a++)
          mem[l][a] <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          lbn_q  <= req_lbn;
          data_q <= req_data;
          mode_q <= req_recompute;
          state  <= S_MAP;
        end
        S_MAP: begin
          stripe_q <= AW'(s_i);
          dlane_q  <= LW'(dat_i);
          plane_q  <= LW'(par_i);
          scan_q   <= '0;
          rd_count <= '0;
          wr_count <= '0;
          acc      <= mode_q ? data_q : '0;
          state    <= mode_q ? S_SCAN : S_RD_OLD;
        end
        S_RD_OLD: begin
          acc      <= mem[dlane_q][stripe_q];
          rd_count <= rd_count + 1'b1;
          state    <= S_RD_PAR;
        end
        S_RD_PAR: begin
          acc      <= acc ^ mem[plane_q][stripe_q];
          rd_count <= rd_count + 1'b1;
          state    <= S_COMPUTE;
        end
        S_COMPUTE: begin
          acc   <= acc ^ data_q;
          state <= S_WR_DATA;
        end
        S_SCAN: begin
          if (scan_q != dlane_q && scan_q != plane_q) begin
            acc      <= acc ^ mem[scan_q][stripe_q];
            rd_count <= rd_count + 1'b1;
          end
          if (scan_q == LW'(LANES - 1)) state <= S_WR_DATA;
          else scan_q <= scan_q + 1'b1;
        end
        S_WR_DATA: begin
          mem[dlane_q][stripe_q] <= data_q;
          wr_count <= wr_count + 1'b1;
          state    <= S_WR_PAR;
        end
        S_WR_PAR: begin
          mem[plane_q][stripe_q] <= acc;
          wr_count <= wr_count + 1'b1;
          state    <= S_DONE;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [DW-1:0] stripe_xor;
  always_comb begin
    stripe_xor = '0;
    for (int l = 0; l < LANES; l++) stripe_xor = stripe_xor ^ mem[l][stripe_q];
  end

  p_stripe_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> stripe_xor == '0);
  p_delta_counts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_q) |-> (rd_count == CW'(2) && wr_count == CW'(2)));
  p_scan_counts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q) |-> (rd_count == CW'(N - 1) && wr_count == CW'(2)));
  p_busy_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_par_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(state == S_WR_PAR));

endmodule

// File: tb/rot_parity_updater_tb.sv
module rot_parity_updater_tb;
  localparam int N = 4, DW = 8, DEPTH = 8;
  localparam int LANES = N + 1;
  localparam int LW = $clog2(LANES), AW = $clog2(DEPTH);
  localparam int LBW = $clog2(N * DEPTH), CW = $clog2(N + 1) + 1;
  localparam int NV = 14;

  // {mode, lbn, data}
  localparam logic [LBW+DW:0] VEC [NV] = '{
    {1'b0, 5'd0,  8'hA5}, {1'b0, 5'd3,  8'h3C}, {1'b0, 5'd5,  8'h11},
    {1'b0, 5'd7,  8'hF0}, {1'b0, 5'd18, 8'h5A}, {1'b0, 5'd16, 8'h81},
    {1'b1, 5'd22, 8'h7E}, {1'b1, 5'd12, 8'h09}, {1'b0, 5'd13, 8'hC3},
    {1'b1, 5'd31, 8'h66}, {1'b1, 5'd0,  8'h42}, {1'b1, 5'd5,  8'hEE},
    {1'b0, 5'd18, 8'h00}, {1'b1, 5'd9,  8'hB7}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_recompute = 0;
  logic [LBW-1:0] req_lbn = '0;
  logic [DW-1:0]  req_data = '0;
  logic req_ready, done;
  logic [CW-1:0] rd_count, wr_count;
  logic [LW-1:0] peek_lane = '0;
  logic [AW-1:0] peek_addr = '0;
  logic [DW-1:0] peek_data;

  logic [DW-1:0] expm [LANES][DEPTH];
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  rot_parity_updater #(.N(N), .DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_lbn(req_lbn), .req_data(req_data), .req_recompute(req_recompute),
    .done(done), .rd_count(rd_count), .wr_count(wr_count),
    .peek_lane(peek_lane), .peek_addr(peek_addr), .peek_data(peek_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input int b, input logic [DW-1:0] d);
    int s, p, i, dl;
    logic [DW-1:0] x;
    s = b / N; i = b % N; p = N - (s % LANES);
    dl = (i < p) ? i : i + 1;
    expm[dl][s] = d;
    x = '0;
    for (int l = 0; l < LANES; l++) if (l != p) x = x ^ expm[l][s];
    expm[p][s] = x;
  endtask

  task automatic peek(input int l, input int a, output logic [DW-1:0] v);
    peek_lane = LW'(l); peek_addr = AW'(a);
    #1 v = peek_data;
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    logic [DW-1:0] v;
    for (int l = 0; l < LANES; l++)
      for (int a = 0; a < DEPTH; a++) begin
        peek(l, a, v);
        if (v !== expm[l][a]) bad++;
      end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic stripe_zero(input int s);
    logic [DW-1:0] v, x;
    x = '0;
    for (int l = 0; l < LANES; l++) begin peek(l, s, v); x = x ^ v; end
    chk(x == '0, "R3 stripe xor", int'(x), 0);
  endtask

  task automatic wait_done(output bit seen);
    int t = 0;
    seen = 0;
    while (t < 100 && !seen) begin
      @(negedge clk);
      if (done) seen = 1;
      t++;
    end
  endtask

  task automatic issue(input int b, input logic [DW-1:0] d, input logic m);
    @(negedge clk);
    req_valid = 1; req_lbn = LBW'(b); req_data = d; req_recompute = m;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit seen;
    logic [DW-1:0] v;
    int cnt;
    for (int l = 0; l < LANES; l++)
      for (int a = 0; a < DEPTH; a++) expm[l][a] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    chk(req_ready == 1'b1, "R2 ready", int'(req_ready), 1);
    chk(done == 1'b0, "R2 done", int'(done), 0);
    chk(rd_count == '0 && wr_count == '0, "R2 counters", int'(rd_count) + int'(wr_count), 0);
    cmp_mem("R2 lanes zero");

    for (int k = 0; k < NV; k++) begin
      logic m;
      int b;
      logic [DW-1:0] d;
      m = VEC[k][LBW+DW]; b = int'(VEC[k][LBW+DW-1:DW]); d = VEC[k][DW-1:0];
      issue(b, d, m);
      model(b, d);
      wait_done(seen);
      chk(seen, "R7 done seen", int'(seen), 1);
      if (!m) begin
        chk(rd_count == CW'(2), "R4 reads", int'(rd_count), 2);
        chk(wr_count == CW'(2), "R4 writes", int'(wr_count), 2);
      end else begin
        chk(rd_count == CW'(N - 1), "R5 reads", int'(rd_count), N - 1);
        chk(wr_count == CW'(2), "R5 writes", int'(wr_count), 2);
      end
      @(negedge clk);
      chk(done == 1'b0, "R7 pulse width", int'(done), 0);
      cmp_mem("R8 R1 R9 lane contents");
      stripe_zero(b / N);
    end

    // R1 explicit: block 7 -> stripe 1, parity lane 3, position 3 -> lane 4
    issue(7, 8'h2D, 1'b0); model(7, 8'h2D); wait_done(seen);
    peek(4, 1, v);
    chk(v == 8'h2D, "R1 lane4 addr1", int'(v), 8'h2D);
    // R7 counters hold
    repeat (5) @(negedge clk);
    chk(rd_count == CW'(2) && wr_count == CW'(2), "R7 counters hold", int'(rd_count), 2);

    // R6 requests while busy are ignored
    issue(26, 8'h99, 1'b0); model(26, 8'h99);
    req_valid = 1; req_lbn = LBW'(1); req_data = 8'hFF; req_recompute = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b0, "R6 busy not ready", int'(req_ready), 0);
    @(negedge clk);
    req_valid = 0;
    wait_done(seen);
    cnt = 0;
    repeat (20) begin @(negedge clk); if (done) cnt++; end
    chk(cnt == 0, "R6 no extra completion", cnt, 0);
    cmp_mem("R6 busy request ignored");

    // R6/R7 held request overlapping completion
    @(negedge clk);
    req_valid = 1; req_lbn = LBW'(10); req_data = 8'h3E; req_recompute = 1'b1;
    @(negedge clk);
    req_lbn = LBW'(30); req_data = 8'hD4; req_recompute = 1'b0;
    model(10, 8'h3E);
    wait_done(seen);
    chk(req_ready == 1'b0, "R6 not ready at done", int'(req_ready), 0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R6 ready after done", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 0;
    model(30, 8'hD4);
    wait_done(seen);
    chk(seen, "R6 held request completes", int'(seen), 1);
    chk(rd_count == CW'(2), "R4 held delta reads", int'(rd_count), 2);
    @(negedge clk);
    cmp_mem("R6 R8 ordered result");
    stripe_zero(30 / N);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule